// File: doc/BRIEF.md
# Radix-4 Sequential Multiplier with Accumulate

This block multiplies two 32-bit operands over several clock cycles. It uses a single adder/subtractor and a single shifter. On each cycle it retires two bits of the multiplier. The two bits and a one-bit carry saved from the previous cycle select one of three actions on the accumulator: skip, add the multiplicand, or subtract the multiplicand. They also select whether the multiplicand is shifted by an even or an odd amount, and they set the carry for the next cycle. The result is the low 32 bits of the product. All arithmetic wraps modulo 2^32, so signed and unsigned operands give the same low word.

A multiply-accumulate uses the same sequence. When the accumulate enable is high at start, the accumulator is seeded with the addend instead of zero. The operation stops early once the multiplier bits still to be consumed are all zero and the saved carry is clear. A small multiplier therefore finishes in few cycles, and the longest operation takes sixteen steps. A one-cycle done pulse marks a finished result. The product output holds that value until the next operation is accepted.

Top module: `radix4_seq_mul`

## Requirements
- R1: After a synchronous reset, `product` is 0 and `done` is 0.
- R2: A `start` sampled while idle loads the accumulator with `addend` when `acc_en` is 1, or with 0 when it is 0. It also clears the saved carry and the step count, and captures `mcand` and `mplier`.
- R3: On the cycle `done` is high, `product` equals (mcand * mplier + (acc_en ? addend : 0)) mod 2^32, using the operands captured at start.
- R4: Step N (N = 0, 1, ...) uses multiplier bits [2N+1:2N] as pair p and the saved carry c. For c=0: p=00 skips (carry 0), p=01 adds mcand<<2N (carry 0), p=10 subtracts mcand<<(2N+1) (carry 1), p=11 subtracts mcand<<2N (carry 1). For c=1: p=00 adds mcand<<2N (carry 0), p=01 adds mcand<<(2N+1) (carry 0), p=10 subtracts mcand<<2N (carry 1), p=11 skips (carry 1).
- R5: The operation takes S steps, one per clock. S is the smallest n in 1..16 with mplier >> (2n-1) equal to 0, or 16 if there is none. `done` is high in the cycle that follows the S-th clock edge after the edge that sampled `start`.
- R6: `done` is high for exactly one cycle per operation. `product` keeps the result until the next accepted start.
- R7: A `start` asserted while an operation is in progress has no effect. The running operation finishes with its own result and latency.
- R8: No operation takes more than 16 steps, even when the carry is still set after the last multiplier pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier, consumed two bits per step |
| addend | input | 32 | Initial accumulator value for multiply-accumulate |
| acc_en | input | 1 | Seed the accumulator with addend |
| product | output | 32 | Low 32 bits of the result, registered |
| done | output | 1 | One-cycle pulse when product is final |

## Verification
The result is due S clock edges after the edge that samples start, where S depends only on the multiplier's highest set bit (R5). The bench computes S from the operand with its own function. It drives start at a falling edge and samples every falling edge after that. It requires done to be low up to the expected sample and high exactly there, and it reads the product in that same sample. It then checks one sample later that done has dropped and the product is still held. Extra start pulses are injected in the middle of long operations, and the same latency and product checks are applied there.

// File: rtl/radix4_pkg.sv
package radix4_pkg;

  typedef enum logic [1:0] {
    R4_SKIP = 2'd0,
    R4_ADD  = 2'd1,
    R4_SUB  = 2'd2
  } r4_op_e;

  typedef struct packed {
    r4_op_e op;     // accumulator action
    logic   odd;    // 1: shift by 2N+1, 0: shift by 2N
    logic   cout;   // carry kept for the next step
  } r4_step_t;

endpackage

// File: rtl/radix4_recode.sv
module radix4_recode
  import radix4_pkg::*;
(
  input  logic [1:0] pair,
  input  logic       cin,
  output r4_step_t   step
);
  always_comb begin
    step = '{op: R4_SKIP, odd: 1'b0, cout: 1'b0};
    unique case ({cin, pair})
      3'b0_00: step = '{op: R4_SKIP, odd: 1'b0, cout: 1'b0};
      3'b0_01: step = '{op: R4_ADD,  odd: 1'b0, cout: 1'b0};
      3'b0_10: step = '{op: R4_SUB,  odd: 1'b1, cout: 1'b1};
      3'b0_11: step = '{op: R4_SUB,  odd: 1'b0, cout: 1'b1};
      3'b1_00: step = '{op: R4_ADD,  odd: 1'b0, cout: 1'b0};
      3'b1_01: step = '{op: R4_ADD,  odd: 1'b1, cout: 1'b0};
      3'b1_10: step = '{op: R4_SUB,  odd: 1'b0, cout: 1'b1};
      3'b1_11: step = '{op: R4_SKIP, odd: 1'b0, cout: 1'b1};
      default: step = '{op: R4_SKIP, odd: 1'b0, cout: 1'b0};
    endcase
  end
endmodule

// File: rtl/radix4_addsub.sv
module radix4_addsub
  import radix4_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = 6
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] mcand,
  input  logic [SHW-1:0]   shamt,
  input  r4_op_e           op,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] operand;
  logic             cin;

  always_comb begin
    shifted = mcand << shamt;
    unique case (op)
      R4_ADD:  begin operand = shifted;  cin = 1'b0; end
      R4_SUB:  begin operand = ~shifted; cin = 1'b1; end
      default: begin operand = '0;       cin = 1'b0; end
    endcase
    sum = acc + operand + {{(WIDTH-1){1'b0}}, cin};
  end
endmodule

// File: rtl/radix4_finish.sv
module radix4_finish #(
  parameter int WIDTH = 32,
  parameter int STEPS = 16,
  parameter int CNTW  = 5
) (
  input  logic [WIDTH-1:0] mplier_nxt,
  input  logic             carry_nxt,
  input  logic [CNTW-1:0]  step_nxt,
  output logic             last
);
  always_comb begin
    last = ((mplier_nxt == '0) && !carry_nxt) || (step_nxt == CNTW'(STEPS));
  end
endmodule

// File: rtl/radix4_seq_mul.sv
module radix4_seq_mul
  import radix4_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  input  logic [WIDTH-1:0] addend,
  input  logic             acc_en,
  output logic [WIDTH-1:0] product,
  output logic             done
);
  localparam int STEPS = WIDTH / 2;
  localparam int CNTW  = $clog2(STEPS + 1);
  localparam int SHW   = CNTW + 1;

  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] mplier_q;
  logic             carry_q;
  logic [CNTW-1:0]  step_q;
  logic             busy_q;
  logic             done_q;

  r4_step_t         dec;
  logic [SHW-1:0]   shamt;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] mplier_nxt;
  logic [CNTW-1:0]  step_nxt;
  logic             last;

  radix4_recode u_recode (
    .pair (mplier_q[1:0]),
    .cin  (carry_q),
    .step (dec)
  );

  always_comb begin
    shamt      = {step_q, 1'b0} + {{(SHW-1){1'b0}}, dec.odd};
    mplier_nxt = mplier_q >> 2;
    step_nxt   = step_q + 1'b1;
  end

  radix4_addsub #(.WIDTH(WIDTH), .SHW(SHW)) u_addsub (
    .acc   (acc_q),
    .mcand (mcand_q),
    .shamt (shamt),
    .op    (dec.op),
    .sum   (sum)
  );

  radix4_finish #(.WIDTH(WIDTH), .STEPS(STEPS), .CNTW(CNTW)) u_finish (
    .mplier_nxt (mplier_nxt),
    .carry_nxt  (dec.cout),
    .step_nxt   (step_nxt),
    .last       (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      carry_q  <= 1'b0;
      step_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        acc_q    <= acc_en ? addend : '0;
        mcand_q  <= mcand;
        mplier_q <= mplier;
        carry_q  <= 1'b0;
        step_q   <= '0;
        busy_q   <= 1'b1;
      end else if (busy_q) begin
        acc_q    <= sum;
        mplier_q <= mplier_nxt;
        carry_q  <= dec.cout;
        step_q   <= step_nxt;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign product = acc_q;
  assign done    = done_q;

endmodule

// File: rtl/radix4_seq_mul_chk.sv
module radix4_seq_mul_chk #(
  parameter int WIDTH = 32,
  parameter int CNTW  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic             busy,
  input logic [CNTW-1:0]  cnt,
  input logic [WIDTH-1:0] mreg,
  input logic             carry
);
  localparam int STEPS = WIDTH / 2;

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: an accepted start clears the step count and carry
  a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && cnt == '0 && !carry));

  // R7: start during an operation does not restart the step count
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (cnt == $past(cnt) + 1'b1));

  // R8: step count stays below its bound while running
  a_r8_step_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CNTW'(STEPS)));

  // R5: completion only on exhausted multiplier with clear carry, or at the bound
  a_r5_end_rule: assert property (@(posedge clk) disable iff (rst)
    done |-> (((mreg == '0) && !carry) || (cnt == CNTW'(STEPS))) && !busy);
endmodule

bind radix4_seq_mul radix4_seq_mul_chk #(.WIDTH(WIDTH), .CNTW(CNTW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .done  (done),
  .busy  (busy_q),
  .cnt   (step_q),
  .mreg  (mplier_q),
  .carry (carry_q)
);

// File: tb/radix4_seq_mul_tb.sv
module radix4_seq_mul_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic [W-1:0] addend = '0;
  logic         acc_en = 1'b0;
  logic [W-1:0] product;
  logic         done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  radix4_seq_mul #(.WIDTH(W)) u_dut (
    .clk, .rst, .start, .mcand, .mplier, .addend, .acc_en, .product, .done
  );

  function automatic int exp_steps(logic [W-1:0] b);
    for (int n = 1; n <= 16; n++)
      if ((b >> (2*n-1)) == 0) return n;
    return 16;
  endfunction

  function automatic logic [W-1:0] exp_prod(logic [W-1:0] a, logic [W-1:0] b,
                                            logic [W-1:0] c, logic en);
    logic [63:0] full;
    full = 64'(a) * 64'(b);
    return full[W-1:0] + (en ? c : '0);
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Runs one operation; if poke is set, start pulses with other operands mid-run (R7).
  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c,
                        logic en, bit poke);
    int s;
    int seen;
    logic [W-1:0] ep;
    s  = exp_steps(b);
    ep = exp_prod(a, b, c, en);
    start = 1'b1; mcand = a; mplier = b; addend = c; acc_en = en;
    seen = 0;
    for (int j = 1; j <= s + 1; j++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && j == 2) begin
        start = 1'b1; mcand = ~a; mplier = 32'h0000_0001; addend = 32'h5555_5555;
        acc_en = ~en;
      end
      if (j <= s && done) seen++;
    end
    start = 1'b0;
    // R5: no early done, done exactly at step s
    check(seen == 0, "R5 early done", W'(seen), '0);
    check(done == 1'b1, poke ? "R7 done latency" : "R5 done latency",
          W'(done), W'(1));
    // R3 / R4 result
    check(product == ep, poke ? "R7 product" : "R3 product", product, ep);
    @(negedge clk);
    check(done == 1'b0, "R6 done pulse width", W'(done), '0);
    check(product == ep, "R6 product held", product, ep);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1B3D));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(product == '0, "R1 product reset", product, '0);
    check(done == 1'b0, "R1 done reset", W'(done), '0);

    // Directed corners
    run_op(32'h1234_5678, 32'h0, 32'h0, 1'b0, 0);          // R5 zero multiplier: 1 step
    run_op(32'h1234_5678, 32'h1, 32'h0, 1'b0, 0);
    run_op(32'h0, 32'hFFFF_FFFF, 32'h0, 1'b0, 0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0, 0);  // R8: 16 steps, carry set
    run_op(32'hAAAA_AAAA, 32'h5555_5555, 32'h0, 1'b0, 0);  // R4 alternating pairs
    run_op(32'h5555_5555, 32'hAAAA_AAAA, 32'h0, 1'b0, 0);
    run_op(32'h0000_0003, 32'h0000_0002, 32'h0, 1'b0, 0);  // R4 c=0 p=10 path
    run_op(32'h0000_0007, 32'h0000_000E, 32'h0, 1'b0, 0);  // R4 carry chain
    run_op(32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0, 0);
    // R2 accumulate seeding
    run_op(32'h0000_0003, 32'h0000_0005, 32'h0000_0100, 1'b1, 0);
    run_op(32'h0, 32'h0, 32'hDEAD_BEEF, 1'b1, 0);
    run_op(32'h0000_0003, 32'h0000_0005, 32'hDEAD_BEEF, 1'b0, 0); // addend ignored
    // R7 start ignored while running
    run_op(32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'h1111_1111, 1'b1, 1);
    run_op(32'hCAFE_F00D, 32'h8000_0001, 32'h0, 1'b0, 1);

    // Constrained random: vary multiplier length to spread latencies
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b, c;
      int len;
      a   = $urandom;
      c   = $urandom;
      len = $urandom_range(32, 1);
      b   = $urandom;
      if (len < 32) b = b & ((32'h1 << len) - 1);
      run_op(a, b, c, 1'($urandom_range(1, 0)), (i % 25) == 0);
    end

    summary();
    $finish;
  end
endmodule